// File: doc/BRIEF.md
# Dual-Rail Return-to-Null Logic Stage

This block is one stage of a dual-rail pipeline in which every logical signal travels on two complementary wires and each evaluation is followed by a null spacer. A slow power-clock phase, sampled by the free-running system clock, paces the stage. When that phase goes high, the stage computes a selectable two-input Boolean function of its two dual-rail operands. It keeps the result on its output pair while the phase stays high. When the phase goes low, it drops both output wires low. A stage downstream that captures on the other phase therefore sees a spacer rather than old data.

Every function comes from one of two small cores, a conjunction and an exclusive-or. The other functions are reached by exchanging the wires of operand A, operand B or the result. The stage also watches its operands. It reports a malformed pair at capture time, and it reports a capture whose operands never went to the spacer during the preceding low phase. That second case is the sign that neighbouring stages are out of step.

Top module: `dr_null_stage`

## Requirements
- R1: A dual-rail value is valid when exactly one of its wires is high. The high wire set means logic 1 and the low wire set means logic 0. Both wires low is the null spacer.
- R2: The select code `fn` sets the function as follows: 0 A AND B, 1 A OR B, 2 NAND, 3 NOR, 4 XOR, 5 XNOR, 6 (NOT A) AND B, 7 A AND (NOT B). For valid operands, `z_hi` equals the function and `z_lo` equals its complement.
- R3: A rising phase edge is seen after SYNC_STAGES system-clock edges. The result appears on the next edge, which is edge SYNC_STAGES+1 after the phase goes high. It then stays unchanged for as long as the phase stays high.
- R4: SYNC_STAGES+1 clock edges after the phase goes low, both output wires are low, and they stay low for as long as the phase stays low.
- R5: At a capture where either operand pair has equal wires (both low or both high), `in_err` is high for exactly one cycle. It stays low at a capture where both pairs are valid.
- R6: If, since the previous capture, the operands were never all four wires low while the phase was low, the next capture raises `tim_err` for exactly one cycle. The first capture after reset never raises it.
- R7: Driving `rst_n` low forces both output wires and both flags low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk | input | 1 | Power-clock phase, asynchronous to clk |
| fn | input | 3 | Static function select code |
| a_lo | input | 1 | Operand A, logic-0 wire |
| a_hi | input | 1 | Operand A, logic-1 wire |
| b_lo | input | 1 | Operand B, logic-0 wire |
| b_hi | input | 1 | Operand B, logic-1 wire |
| z_lo | output | 1 | Result, logic-0 wire |
| z_hi | output | 1 | Result, logic-1 wire |
| in_err | output | 1 | One-cycle pulse for a malformed operand at capture |
| tim_err | output | 1 | One-cycle pulse for a capture without a preceding spacer |

## Verification
The bench builds the stage with the default SYNC_STAGES of 2 and derives its sampling point from that value, so every output is checked at edge three after a phase change. It also checks one cycle later to confirm the hold and the single-cycle width of the flag pulses. With this short chain, all eight select codes across all four operand combinations fit in a few thousand cycles. The same holds for the spacer-skipping sequence that provokes the timing flag and for a reset dropped in the middle of an evaluation.

// File: rtl/dr_null_stage.sv
module dr_null_stage #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pclk,
  input  logic [2:0] fn,
  input  logic       a_lo,
  input  logic       a_hi,
  input  logic       b_lo,
  input  logic       b_hi,
  output logic       z_lo,
  output logic       z_hi,
  output logic       in_err,
  output logic       tim_err
);

  logic [SYNC_STAGES-1:0] sync;
  logic pc_d, rise, fall;
  logic swap_a, swap_b, swap_z, use_xor;
  logic ah, al, bh, bl, eh, el;
  logic bad_in, in_null, seen_null;

  wire pc_q = sync[SYNC_STAGES-1];
  assign rise = pc_q & ~pc_d;
  assign fall = ~pc_q & pc_d;

  always_comb begin
    {swap_a, swap_b, swap_z, use_xor} = 4'b0000;
    case (fn)
      3'd1: {swap_a, swap_b, swap_z} = 3'b111;
      3'd2: swap_z = 1'b1;
      3'd3: {swap_a, swap_b} = 2'b11;
      3'd4: use_xor = 1'b1;
      3'd5: {use_xor, swap_z} = 2'b11;
      3'd6: swap_a = 1'b1;
      3'd7: swap_b = 1'b1;
      default: ;
    endcase
  end

  assign ah = swap_a ? a_lo : a_hi;
  assign al = swap_a ? a_hi : a_lo;
  assign bh = swap_b ? b_lo : b_hi;
  assign bl = swap_b ? b_hi : b_lo;
  assign eh = use_xor ? ((ah & bl) | (al & bh)) : (ah & bh);
  assign el = use_xor ? ((ah & bh) | (al & bl)) : (al | bl);

  assign bad_in  = (a_lo == a_hi) | (b_lo == b_hi);
  assign in_null = ~|{a_lo, a_hi, b_lo, b_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= '0;
      pc_d      <= 1'b0;
      z_lo      <= 1'b0;
      z_hi      <= 1'b0;
      in_err    <= 1'b0;
      tim_err   <= 1'b0;
      seen_null <= 1'b1;
    end else begin
      sync    <= {sync[SYNC_STAGES-2:0], pclk};
      pc_d    <= pc_q;
      in_err  <= rise & bad_in;
      tim_err <= rise & ~seen_null;
      if (rise) begin
        z_hi      <= swap_z ? el : eh;
        z_lo      <= swap_z ? eh : el;
        seen_null <= 1'b0;
      end else begin
        if (fall) begin
          z_hi <= 1'b0;
          z_lo <= 1'b0;
        end
        if (!pc_q && in_null) seen_null <= 1'b1;
      end
    end
  end

  AST_NULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (!z_lo && !z_hi)); // R4
  AST_NULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_q && !pc_d) |-> (!z_lo && !z_hi)); // R4
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q && pc_d) |=> $stable({z_lo, z_hi})); // R3
  AST_IN_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_err |=> !in_err); // R5
  AST_TIM_ERR_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    tim_err |-> $past(rise)); // R6

endmodule

// File: tb/dr_null_stage_test.sv
module dr_null_stage_test;
  localparam int SYNC_STAGES = 2;
  localparam int LAT = SYNC_STAGES + 1;
  // truth tables per select code, bit index {a,b}
  localparam logic [3:0] TT [8] = '{4'b1000, 4'b1110, 4'b0111, 4'b0001,
                                    4'b0110, 4'b1001, 4'b0010, 4'b0100};

  logic clk = 0, rst_n = 0, pclk = 0;
  logic [2:0] fn = 0;
  logic a_lo = 0, a_hi = 0, b_lo = 0, b_hi = 0;
  logic z_lo, z_hi, in_err, tim_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dr_null_stage #(.SYNC_STAGES(SYNC_STAGES)) uut (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .fn(fn),
    .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
    .z_lo(z_lo), .z_hi(z_hi), .in_err(in_err), .tim_err(tim_err));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_ops(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    {a_hi, a_lo} = a;
    {b_hi, b_lo} = b;
  endtask

  task automatic phase(input logic v);
    @(negedge clk);
    pclk = v;
    repeat (LAT) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R7 reset", {z_hi, z_lo, in_err, tim_err}, 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1 chk("R4 idle after reset", {z_hi, z_lo, in_err, tim_err}, 4'b0000);

    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 4; i++) begin
        logic av, bv, e;
        av = i[1]; bv = i[0]; e = TT[f][i];
        @(negedge clk) fn = f[2:0];
        set_ops({av, ~av}, {bv, ~bv});
        phase(1);
        chk("R1 R2 R3 result", {z_hi, z_lo, in_err, tim_err}, {e, ~e, 2'b00});
        repeat (3) @(posedge clk);
        #1 chk("R3 hold", {z_hi, z_lo}, {e, ~e});
        phase(0);
        chk("R4 null", {z_hi, z_lo}, 2'b00);
        set_ops(2'b00, 2'b00);
        repeat (2) @(posedge clk);
      end
    end

    // R5 malformed operand: A both low
    @(negedge clk) fn = 3'd0;
    set_ops(2'b00, 2'b10);
    phase(1);
    chk("R5 in_err both-low", {in_err, tim_err}, 2'b10);
    @(posedge clk); #1 chk("R5 pulse width", {in_err}, 1'b0);
    phase(0);
    set_ops(2'b00, 2'b00);
    repeat (2) @(posedge clk);
    // R5 malformed operand: B both high
    set_ops(2'b10, 2'b11);
    phase(1);
    chk("R5 in_err both-high", {in_err, tim_err}, 2'b10);
    @(posedge clk); #1 chk("R5 pulse width", {in_err}, 1'b0);
    phase(0);
    chk("R4 null after bad", {z_hi, z_lo}, 2'b00);

    // R6: operands stay valid through the low phase (no spacer)
    set_ops(2'b10, 2'b10);
    repeat (3) @(posedge clk);
    phase(1);
    chk("R6 tim_err", {z_hi, z_lo, in_err, tim_err}, 4'b1001);
    @(posedge clk); #1 chk("R6 pulse width", {tim_err}, 1'b0);
    phase(0);
    set_ops(2'b00, 2'b00);
    repeat (2) @(posedge clk);
    set_ops(2'b10, 2'b01);
    phase(1);
    chk("R6 clean after spacer", {z_hi, z_lo, in_err, tim_err}, 4'b0100);

    // R7 asynchronous reset during evaluation
    @(negedge clk) pclk = 0;
    #3 rst_n = 0;
    #1 chk("R7 async clear", {z_hi, z_lo, in_err, tim_err}, 4'b0000);
    @(negedge clk) rst_n = 1;
    set_ops(2'b10, 2'b10);
    phase(1);
    chk("R6 first capture after reset", {z_hi, z_lo, tim_err}, 3'b100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule